// File: doc/BRIEF.md
# Ascon Permutation Round Core

This block applies the Ascon permutation to a 320-bit state held as five 64-bit words. It computes one round per clock cycle from a single round datapath and supports two invocation lengths: the full 12-round permutation and a reduced 8-round form. The surrounding sponge logic loads a state, pulses start, waits for done and reads the permuted state. Padding, the sponge mode, key handling and masking are left to that surrounding logic.

Each round has three steps in a fixed order. First a round constant is added. Then a bitsliced nonlinear substitution built from AND, NOT and XOR mixes the five words column by column. Finally a linear diffusion step XORs each word with two right-rotated copies of itself. The reduced form runs the last eight rounds of the full constant schedule. Both forms therefore share the same constant generator and the same completion point.

Top module: `ascon_perm_core`

## Requirements
- R1: While rst_ni is low and after it rises, busy_o and done_o are 0 and state_o is all zeros.
- R2: When start_i is 1 at a rising clock edge while busy_o is 0, busy_o is 1 after that edge and state_o equals the sampled state_i.
- R3: With rounds_sel_i = 0 at start, done_o rises exactly 12 clock edges after the start edge, and state_o then equals the 12-round permutation of the loaded state.
- R4: With rounds_sel_i = 1 at start, done_o rises exactly 8 clock edges after the start edge, and state_o then equals 8 rounds of the permutation using schedule indices 4 through 11.
- R5: For schedule index i in 0..11, the round constant is ((15 - i) << 4) | i. It is XORed into bits 7:0 of word x2 before the substitution step of that round.
- R6: The substitution step, applied in this order on whole words, is: x0 ^= x4; x4 ^= x3; x2 ^= x1; then simultaneously x_i ^= ~x_(i+1 mod 5) & x_(i+2 mod 5) for i in 0..4; then x1 ^= x0; x0 ^= x4; x3 ^= x2; x2 = ~x2.
- R7: The diffusion step sets each word to w ^ ror(w,a) ^ ror(w,b), with (a,b) equal to (19,28) for x0, (61,39) for x1, (1,6) for x2, (10,17) for x3 and (7,41) for x4.
- R8: done_o is high for exactly one cycle per permutation, and busy_o is 0 whenever done_o is 1.
- R9: While busy_o is 0 and no start is accepted, state_o holds its value.
- R10: A start_i pulse while busy_o is 1 is ignored. It changes neither the result nor the completion cycle.
- R11: Word x0 sits at bits 319:256 of state_i and state_o, x1 at 255:192, x2 at 191:128, x3 at 127:64 and x4 at 63:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load state_i and begin a permutation when idle |
| rounds_sel_i | input | 1 | 0 selects 12 rounds, 1 selects 8 rounds |
| state_i | input | 320 | State to be permuted, x0 in the top word |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse when the last round is applied |
| state_o | output | 320 | Working state; holds the result after done |

## Verification
The bench builds the core with its default parameters: a 12-round full schedule and an 8-round reduced form. This is the only configuration the constant formula covers. A walking single-bit input is swept across all 320 state positions in both round modes, alongside all-zeros and all-ones states. This drives a lone difference through every substitution column and every rotation path. It also exercises both ends of the constant schedule. Some runs inject a start pulse mid-permutation to show that it is ignored. Every run also checks completion latency, the one-cycle done pulse and that the result holds afterwards.

// File: rtl/ascon_pkg.sv
package ascon_pkg;
  localparam int WORD_W    = 64;
  localparam int NUM_WORDS = 5;
  localparam int STATE_W   = WORD_W * NUM_WORDS;
  localparam int RC_W      = 8;

  typedef logic [WORD_W-1:0] word_t;

  // rotation pairs per word index
  localparam int unsigned ROT_A [NUM_WORDS] = '{19, 61, 1, 10, 7};
  localparam int unsigned ROT_B [NUM_WORDS] = '{28, 39, 6, 17, 41};

  function automatic word_t ror_w(input word_t w, input int unsigned r);
    return (w >> r) | (w << (WORD_W - r));
  endfunction

  // x0 occupies the most significant word
  function automatic int unsigned word_lsb(input int unsigned i);
    return (NUM_WORDS - 1 - i) * WORD_W;
  endfunction
endpackage

// File: rtl/ascon_const_add.sv
module ascon_const_add
  import ascon_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [STATE_W-1:0] state_o
);
  localparam int unsigned X2_LSB = word_lsb(2);

  logic [3:0]      idx4;
  logic [RC_W-1:0] rc;

  assign idx4 = 4'(idx_i);
  assign rc   = {4'hF - idx4, idx4};

  always_comb begin
    state_o = state_i;
    state_o[X2_LSB +: RC_W] = state_i[X2_LSB +: RC_W] ^ rc;
  end
endmodule

// File: rtl/ascon_sbox_layer.sv
module ascon_sbox_layer
  import ascon_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o
);
  word_t x [NUM_WORDS];
  word_t a [NUM_WORDS];
  word_t b [NUM_WORDS];
  word_t y [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_unpack
    assign x[i] = state_i[word_lsb(i) +: WORD_W];
  end

  // input mixing
  assign a[0] = x[0] ^ x[4];
  assign a[1] = x[1];
  assign a[2] = x[2] ^ x[1];
  assign a[3] = x[3];
  assign a[4] = x[4] ^ x[3];

  // nonlinear step, all five words in parallel
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_chi
    assign b[i] = a[i] ^ (~a[(i + 1) % NUM_WORDS] & a[(i + 2) % NUM_WORDS]);
  end

  // output mixing
  assign y[1] = b[1] ^ b[0];
  assign y[0] = b[0] ^ b[4];
  assign y[3] = b[3] ^ b[2];
  assign y[2] = ~b[2];
  assign y[4] = b[4];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_pack
    assign state_o[word_lsb(i) +: WORD_W] = y[i];
  end
endmodule

// File: rtl/ascon_lin_layer.sv
module ascon_lin_layer
  import ascon_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    word_t w;
    assign w = state_i[word_lsb(i) +: WORD_W];
    assign state_o[word_lsb(i) +: WORD_W] = w ^ ror_w(w, ROT_A[i]) ^ ror_w(w, ROT_B[i]);
  end
endmodule

// File: rtl/ascon_round.sv
module ascon_round
  import ascon_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] after_rc;
  logic [STATE_W-1:0] after_sb;

  ascon_const_add #(.IDX_W(IDX_W)) u_rc (
    .state_i (state_i),
    .idx_i   (idx_i),
    .state_o (after_rc)
  );

  ascon_sbox_layer u_sb (
    .state_i (after_rc),
    .state_o (after_sb)
  );

  ascon_lin_layer u_lin (
    .state_i (after_sb),
    .state_o (state_o)
  );
endmodule

// File: rtl/ascon_perm_core.sv
module ascon_perm_core
  import ascon_pkg::*;
#(
  parameter int FULL_ROUNDS  = 12,
  parameter int SHORT_ROUNDS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               rounds_sel_i,
  input  logic [STATE_W-1:0] state_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [STATE_W-1:0] state_o
);
  localparam int CNT_W = $clog2(FULL_ROUNDS);
  localparam logic [CNT_W-1:0] LAST_IDX    = CNT_W'(FULL_ROUNDS - 1);
  localparam logic [CNT_W-1:0] SHORT_START = CNT_W'(FULL_ROUNDS - SHORT_ROUNDS);

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] round_out;
  logic [CNT_W-1:0]   idx_q;
  logic               busy_q;
  logic               done_q;
  logic               accept;

  assign accept = start_i & ~busy_q;

  ascon_round #(.IDX_W(CNT_W)) u_round (
    .state_i (state_q),
    .idx_i   (idx_q),
    .state_o (round_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= state_i;
        idx_q   <= rounds_sel_i ? SHORT_START : '0;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        state_q <= round_out;
        idx_q   <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign state_o = state_q;
endmodule

// File: rtl/ascon_perm_core_chk.sv
module ascon_perm_core_chk
  import ascon_pkg::*;
#(
  parameter int FULL_ROUNDS  = 12,
  parameter int SHORT_ROUNDS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               rounds_sel_i,
  input logic [STATE_W-1:0] state_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [STATE_W-1:0] state_o
);
  localparam int LAT_W = $clog2(FULL_ROUNDS + 2);

  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      exp_q <= '0;
    end else if (start_i && !busy_o) begin
      lat_q <= '0;
      exp_q <= rounds_sel_i ? LAT_W'(SHORT_ROUNDS) : LAT_W'(FULL_ROUNDS);
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && state_o == $past(state_i)));

  // R3 R4 R10
  round_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == exp_q));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(state_o));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!busy_o && !done_o && state_o == '0);
    end
  end
endmodule

bind ascon_perm_core ascon_perm_core_chk #(
  .FULL_ROUNDS  (FULL_ROUNDS),
  .SHORT_ROUNDS (SHORT_ROUNDS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .rounds_sel_i (rounds_sel_i),
  .state_i      (state_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .state_o      (state_o)
);

// File: tb/ascon_perm_core_bench.sv
module ascon_perm_core_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         rounds_sel_i = 1'b0;
  logic [319:0] state_i = '0;
  logic         busy_o;
  logic         done_o;
  logic [319:0] state_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ascon_perm_core u_ascon_perm_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .rounds_sel_i (rounds_sel_i),
    .state_i      (state_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .state_o      (state_o)
  );

  function automatic logic [63:0] ror(input logic [63:0] w, input int r);
    return (w >> r) | (w << (64 - r));
  endfunction

  // reference built from R5, R6, R7, R11
  function automatic logic [319:0] ref_perm(input logic [319:0] s, input int nr);
    logic [63:0] x [5];
    logic [63:0] t [5];
    logic [319:0] o;
    for (int i = 0; i < 5; i++) x[i] = s[319 - 64*i -: 64];
    for (int r = 12 - nr; r < 12; r++) begin
      x[2] = x[2] ^ {56'h0, 4'(15 - r), 4'(r)};
      x[0] ^= x[4]; x[4] ^= x[3]; x[2] ^= x[1];
      for (int i = 0; i < 5; i++) t[i] = ~x[(i+1)%5] & x[(i+2)%5];
      for (int i = 0; i < 5; i++) x[i] ^= t[i];
      x[1] ^= x[0]; x[0] ^= x[4]; x[3] ^= x[2]; x[2] = ~x[2];
      x[0] = x[0] ^ ror(x[0], 19) ^ ror(x[0], 28);
      x[1] = x[1] ^ ror(x[1], 61) ^ ror(x[1], 39);
      x[2] = x[2] ^ ror(x[2], 1)  ^ ror(x[2], 6);
      x[3] = x[3] ^ ror(x[3], 10) ^ ror(x[3], 17);
      x[4] = x[4] ^ ror(x[4], 7)  ^ ror(x[4], 41);
    end
    for (int i = 0; i < 5; i++) o[319 - 64*i -: 64] = x[i];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [319:0] act,
                     input logic [319:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_perm(input logic [319:0] in, input bit sel, input bit poke);
    logic [319:0] exp_s;
    int n;
    int want;
    exp_s = ref_perm(in, sel ? 8 : 12);
    want  = sel ? 8 : 12;
    @(negedge clk_i);
    state_i = in; rounds_sel_i = sel; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; rounds_sel_i = ~sel;
    chk(busy_o === 1'b1 && state_o === in, "R2 load", state_o, in);
    n = 0;
    if (poke) begin
      // R10: restart attempt mid-run
      state_i = ~in; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      n = 1;
    end
    while (!done_o && n < 40) begin
      @(negedge clk_i);
      n++;
    end
    chk(n == want, sel ? "R4 R10 latency" : "R3 R10 latency", 320'(n), 320'(want));
    chk(state_o === exp_s, sel ? "R4 R5 R6 R7 R11 result" : "R3 R5 R6 R7 R11 result",
        state_o, exp_s);
    @(negedge clk_i);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R8 pulse", 320'(done_o), 320'(0));
    state_i = ~state_i;
    @(negedge clk_i);
    chk(state_o === exp_s, "R9 hold", state_o, exp_s);
  endtask

  initial begin
    #1;
    chk(busy_o === 1'b0 && done_o === 1'b0 && state_o === '0, "R1 in reset", state_o, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b0 && done_o === 1'b0 && state_o === '0, "R1 after reset", state_o, '0);
    run_perm('0, 1'b0, 1'b0);
    run_perm('0, 1'b1, 1'b0);
    run_perm('1, 1'b0, 1'b1);
    run_perm('1, 1'b1, 1'b1);
    for (int b = 0; b < 320; b++) begin
      run_perm(320'(1) << b, 1'b0, (b % 7) == 0);
      run_perm(320'(1) << b, 1'b1, (b % 5) == 0);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule